// File: doc/BRIEF.md
# Claim/Complete Register Front End

This block is the memory-mapped register file for a small interrupt controller that serves one target and up to 31 interrupt sources. Sources are numbered 1 to `NUM_SRC`, and ID 0 means "no interrupt". A bus agent uses a plain valid/write/address/data request. Read data comes back in the cycle after the request.

The block stores the configuration that the rest of the controller uses:
- one edge/level select bit per source,
- one priority per source,
- one enable bit per source,
- the target threshold,
- a software interrupt bit.

It also shows the gateways' pending bits as a read-only word. The gateways and the highest-priority selector sit outside the block. The selector's current winner arrives on `sel_id_i`, and the block sends claim and complete events back to the gateways as one-hot pulses.

One word has side effects: the claim/complete register. Reading it returns the selector's winner and claims that source. Writing an ID to it completes that source.

Word map, with byte offset = 4 × word index and address bits [1:0] ignored:

| Word index | Register |
|---|---|
| 0 | pending |
| 1 | edge/level select |
| 2 + i | priority of source i (i = 0 … `NUM_SRC`) |
| `NUM_SRC`+3 | enable |
| `NUM_SRC`+4 | threshold |
| `NUM_SRC`+5 | claim/complete |
| `NUM_SRC`+6 | software interrupt |

Top module: `irqfe_regfront`

## Requirements
- R1: After reset, every configuration output, `claim_o`, `complete_o`, `swi_o` and `rsp_rdata_o` is 0. A read of any configuration register then returns 0.
- R2: A read of word 0 returns `pend_i`, with bit i holding source i and bit 0 forced to 0. A write to word 0 changes no register.
- R3: The edge/level word stores bit i for source i (1 = edge-triggered, 0 = level) and drives it on `edge_sel_o[i]`. Bit 0 and bits above `NUM_SRC` read back as 0.
- R4: The priority word of source i keeps only wdata bits [PRIO_W-1:0], reads back with all upper bits 0, and drives `prio_o[i*PRIO_W +: PRIO_W]`. The source-0 priority word always reads 0.
- R5: The enable word stores bit i for source i, with bit 0 tied to 0. The threshold word keeps bits [PRIO_W-1:0] only, and its upper bits read 0.
- R6: A read of the claim/complete word returns `sel_id_i`. If that ID lies in 1 … `NUM_SRC`, `claim_o` carries a pulse with only bit ID set, for exactly the one cycle after the request. A returned ID of 0 gives no pulse, and a read never pulses `complete_o`.
- R7: A write of value d to the claim/complete word pulses `complete_o` with only bit d set, for the one cycle after the request, when 1 ≤ d ≤ `NUM_SRC`. Any other value (0, or above `NUM_SRC`, compared over all 32 bits) gives no pulse. A write never pulses `claim_o` and changes no configuration register.
- R8: The software interrupt word holds wdata bit 0 and drives `swi_o` from the cycle after the write. Writing 1 sets it, writing 0 clears it, and other bits have no effect.
- R9: A read of an unmapped word returns 0. A write to an unmapped word changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, valid in the cycle after a read request |
| pend_i | input | NUM_SRC+1 | Pending bits from the gateways |
| sel_id_i | input | ID_W | Winner ID from the external selector |
| edge_sel_o | output | NUM_SRC+1 | Per-source edge (1) / level (0) select |
| enable_o | output | NUM_SRC+1 | Per-source enable |
| prio_o | output | (NUM_SRC+1)*PRIO_W | Packed priorities, source i in slice i |
| threshold_o | output | PRIO_W | Target threshold |
| claim_o | output | NUM_SRC+1 | One-hot claim pulse to the gateways |
| complete_o | output | NUM_SRC+1 | One-hot complete pulse to the gateways |
| swi_o | output | 1 | Software interrupt |

## Verification
Every result of a request is registered once:
- configuration outputs, `rsp_rdata_o`, `claim_o` and `complete_o` all change on the first clock edge after the cycle in which the request is presented;
- the pulses fall again one edge later.

The bench drives each request on a falling edge, holds it for one cycle, and samples all outputs on the next falling edge. At that point every result is due and no pulse has yet ended. It then samples once more a cycle later to confirm that each pulse lasted a single cycle. A small configuration (7 sources, 2-bit priority) allows the bench to sweep every source ID and every priority slot, and to compute each expected word by masking in the bench.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

   // Which register a decoded address selects
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PEND,
      SEL_EDGE,
      SEL_PRIO,
      SEL_EN,
      SEL_THR,
      SEL_CC,
      SEL_SWI
   } reg_sel_e;

   // Fixed word indices at the bottom of the map
   localparam int unsigned WORD_PEND  = 0;
   localparam int unsigned WORD_EDGE  = 1;
   localparam int unsigned WORD_PRIO0 = 2;

   // Number of words occupied for a given source count
   function automatic int unsigned map_words(input int unsigned nsrc);
      return WORD_PRIO0 + nsrc + 5;
   endfunction

endpackage

// File: rtl/irqfe_addr_dec.sv
module irqfe_addr_dec
   import irqfe_pkg::*;
#(
   parameter int unsigned NUM_SRC = 31,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned IDX_W   = 5
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o,
   output logic [IDX_W-1:0]  prio_idx_o
);

   localparam int unsigned PRIO_LAST = WORD_PRIO0 + NUM_SRC;
   localparam int unsigned EN_WORD   = PRIO_LAST + 1;
   localparam int unsigned THR_WORD  = PRIO_LAST + 2;
   localparam int unsigned CC_WORD   = PRIO_LAST + 3;
   localparam int unsigned SWI_WORD  = PRIO_LAST + 4;

   logic [31:0] word;
   logic        unused_lsb;

   assign word       = 32'(addr_i[ADDR_W-1:2]);
   assign unused_lsb = ^addr_i[1:0];

   always_comb begin
      sel_o      = SEL_NONE;
      prio_idx_o = '0;
      if (word == WORD_PEND) begin
         sel_o = SEL_PEND;
      end else if (word == WORD_EDGE) begin
         sel_o = SEL_EDGE;
      end else if (word >= WORD_PRIO0 && word <= PRIO_LAST) begin
         sel_o      = SEL_PRIO;
         prio_idx_o = IDX_W'(word - WORD_PRIO0);
      end else if (word == EN_WORD) begin
         sel_o = SEL_EN;
      end else if (word == THR_WORD) begin
         sel_o = SEL_THR;
      end else if (word == CC_WORD) begin
         sel_o = SEL_CC;
      end else if (word == SWI_WORD) begin
         sel_o = SEL_SWI;
      end
   end

endmodule

// File: rtl/irqfe_cfg_regs.sv
module irqfe_cfg_regs
   import irqfe_pkg::*;
#(
   parameter int unsigned NUM_SRC = 31,
   parameter int unsigned PRIO_W  = 2,
   parameter int unsigned IDX_W   = 5
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_i,
   input  reg_sel_e                      sel_i,
   input  logic [IDX_W-1:0]              prio_idx_i,
   input  logic [31:0]                   wdata_i,
   output logic [NUM_SRC:0]              edge_o,
   output logic [NUM_SRC:0]              en_o,
   output logic [(NUM_SRC+1)*PRIO_W-1:0] prio_o,
   output logic [PRIO_W-1:0]             thr_o,
   output logic                          swi_o
);

   logic edge_wr, en_wr, thr_wr, swi_wr, prio_wr;
   logic unused_wdata;

   assign edge_wr      = wr_i && (sel_i == SEL_EDGE);
   assign en_wr        = wr_i && (sel_i == SEL_EN);
   assign thr_wr       = wr_i && (sel_i == SEL_THR);
   assign swi_wr       = wr_i && (sel_i == SEL_SWI);
   assign prio_wr      = wr_i && (sel_i == SEL_PRIO);
   assign unused_wdata = ^wdata_i;

   // Source 0 is reserved: its edge, enable and priority slots are tied off
   assign edge_o[0]            = 1'b0;
   assign en_o[0]              = 1'b0;
   assign prio_o[PRIO_W-1:0]   = '0;

   for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            edge_o[i] <= 1'b0;
            en_o[i]   <= 1'b0;
         end else begin
            if (edge_wr) edge_o[i] <= wdata_i[i];
            if (en_wr)   en_o[i]   <= wdata_i[i];
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prio_o[i*PRIO_W +: PRIO_W] <= '0;
         end else if (prio_wr && (prio_idx_i == IDX_W'(i))) begin
            prio_o[i*PRIO_W +: PRIO_W] <= wdata_i[PRIO_W-1:0];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thr_o <= '0;
         swi_o <= 1'b0;
      end else begin
         if (thr_wr) thr_o <= wdata_i[PRIO_W-1:0];
         if (swi_wr) swi_o <= wdata_i[0];
      end
   end

   // R8: the software interrupt bit follows bit 0 of its write
   a_r8_swi_follows_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
      swi_wr |=> (swi_o == $past(wdata_i[0])));

   // R5: enables only move on an enable write
   a_r5_enable_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_wr |=> $stable(en_o));

   // R5: threshold only moves on a threshold write
   a_r5_threshold_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !thr_wr |=> $stable(thr_o));

endmodule

// File: rtl/irqfe_cc_port.sv
module irqfe_cc_port #(
   parameter int unsigned NUM_SRC = 31,
   parameter int unsigned ID_W    = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cc_rd_i,
   input  logic              cc_wr_i,
   input  logic [ID_W-1:0]   sel_id_i,
   input  logic [31:0]       wdata_i,
   output logic [NUM_SRC:0]  claim_o,
   output logic [NUM_SRC:0]  complete_o
);

   logic [NUM_SRC:0] claim_d, complete_d;

   always_comb begin
      claim_d    = '0;
      complete_d = '0;
      for (int unsigned i = 1; i <= NUM_SRC; i++) begin
         claim_d[i]    = cc_rd_i && (sel_id_i == ID_W'(i));
         complete_d[i] = cc_wr_i && (wdata_i == 32'(i));
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         claim_o    <= '0;
         complete_o <= '0;
      end else begin
         claim_o    <= claim_d;
         complete_o <= complete_d;
      end
   end

   // R6: at most one source claimed at a time
   a_r6_claim_onehot : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(claim_o));

   // R7: at most one source completed at a time
   a_r7_complete_onehot : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(complete_o));

   // R6: a claim pulse is always caused by a claim read
   a_r6_claim_from_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_o != '0) |-> $past(cc_rd_i));

   // R7: a complete pulse is always caused by a claim/complete write
   a_r7_complete_from_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (complete_o != '0) |-> $past(cc_wr_i));

   // R6: a read of a valid ID claims exactly that ID
   a_r6_claim_hits_id : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cc_rd_i && sel_id_i != '0 && 32'(sel_id_i) <= NUM_SRC)
         |=> (claim_o == ((NUM_SRC+1)'(1) << $past(sel_id_i))));

endmodule

// File: rtl/irqfe_regfront.sv
module irqfe_regfront
   import irqfe_pkg::*;
#(
   parameter int unsigned NUM_SRC = 31,
   parameter int unsigned PRIO_W  = 2,
   parameter int unsigned ADDR_W  = 8,
   localparam int unsigned ID_W   = $clog2(NUM_SRC + 1)
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          req_valid_i,
   input  logic                          req_write_i,
   input  logic [ADDR_W-1:0]             req_addr_i,
   input  logic [31:0]                   req_wdata_i,
   output logic [31:0]                   rsp_rdata_o,
   input  logic [NUM_SRC:0]              pend_i,
   input  logic [ID_W-1:0]               sel_id_i,
   output logic [NUM_SRC:0]              edge_sel_o,
   output logic [NUM_SRC:0]              enable_o,
   output logic [(NUM_SRC+1)*PRIO_W-1:0] prio_o,
   output logic [PRIO_W-1:0]             threshold_o,
   output logic [NUM_SRC:0]              claim_o,
   output logic [NUM_SRC:0]              complete_o,
   output logic                          swi_o
);

   localparam int unsigned MAP_BYTES = 4 * map_words(NUM_SRC);

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > 31) begin : g_bad_nsrc
      $error("NUM_SRC must lie in 1..31");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end
   if (ADDR_W < 3 || ADDR_W > 16 || MAP_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   reg_sel_e        sel;
   logic [ID_W-1:0] prio_idx;
   logic            rd, wr;
   logic [31:0]     rdata_d;
   logic            unused_pend0;

   assign rd           = req_valid_i && !req_write_i;
   assign wr           = req_valid_i && req_write_i;
   assign unused_pend0 = pend_i[0];

   irqfe_addr_dec #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W),
      .IDX_W   (ID_W)
   ) u_dec (
      .addr_i     (req_addr_i),
      .sel_o      (sel),
      .prio_idx_o (prio_idx)
   );

   irqfe_cfg_regs #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .IDX_W   (ID_W)
   ) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr),
      .sel_i      (sel),
      .prio_idx_i (prio_idx),
      .wdata_i    (req_wdata_i),
      .edge_o     (edge_sel_o),
      .en_o       (enable_o),
      .prio_o     (prio_o),
      .thr_o      (threshold_o),
      .swi_o      (swi_o)
   );

   irqfe_cc_port #(
      .NUM_SRC (NUM_SRC),
      .ID_W    (ID_W)
   ) u_cc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cc_rd_i    (rd && (sel == SEL_CC)),
      .cc_wr_i    (wr && (sel == SEL_CC)),
      .sel_id_i   (sel_id_i),
      .wdata_i    (req_wdata_i),
      .claim_o    (claim_o),
      .complete_o (complete_o)
   );

   always_comb begin
      unique case (sel)
         SEL_PEND: rdata_d = 32'({pend_i[NUM_SRC:1], 1'b0});
         SEL_EDGE: rdata_d = 32'(edge_sel_o);
         SEL_PRIO: rdata_d = 32'(prio_o[prio_idx*PRIO_W +: PRIO_W]);
         SEL_EN:   rdata_d = 32'(enable_o);
         SEL_THR:  rdata_d = 32'(threshold_o);
         SEL_CC:   rdata_d = 32'(sel_id_i);
         SEL_SWI:  rdata_d = 32'(swi_o);
         default:  rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rsp_rdata_o <= '0;
      else if (rd) rsp_rdata_o <= rdata_d;
   end

   // R9: unmapped reads return zero
   a_r9_unmapped_reads_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && sel == SEL_NONE) |=> (rsp_rdata_o == '0));

   // R6: a claim read returns the selector's ID
   a_r6_claim_returns_id : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && sel == SEL_CC) |=> (rsp_rdata_o == 32'($past(sel_id_i))));

endmodule

// File: tb/irqfe_regfront_tb.sv
module irqfe_regfront_tb_top;

   localparam int unsigned N  = 7;
   localparam int unsigned PW = 2;
   localparam int unsigned AW = 8;
   localparam int unsigned IW = 3;

   localparam logic [7:0] A_PEND = 8'h00;
   localparam logic [7:0] A_EDGE = 8'h04;
   localparam logic [7:0] A_EN   = 8'(4 * (N + 3));
   localparam logic [7:0] A_THR  = 8'(4 * (N + 4));
   localparam logic [7:0] A_CC   = 8'(4 * (N + 5));
   localparam logic [7:0] A_SWI  = 8'(4 * (N + 6));
   localparam logic [31:0] SRC_MASK = 32'h0000_00FE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic [N:0] pend = '0;
   logic [IW-1:0] sel_id = '0;
   logic [N:0] edge_sel, enable, claim, complete;
   logic [(N+1)*PW-1:0] prio;
   logic [PW-1:0] threshold;
   logic swi;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] snap_rdata;
   logic [N:0]  snap_claim, snap_cmp;

   logic [N:0] exp_edge = '0, exp_en = '0;
   logic [(N+1)*PW-1:0] exp_prio = '0;
   logic [PW-1:0] exp_thr = '0;
   logic exp_swi = 1'b0;

   always #4 clk = ~clk;

   irqfe_regfront #(.NUM_SRC(N), .PRIO_W(PW), .ADDR_W(AW)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_write_i (req_write),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .rsp_rdata_o (rsp_rdata),
      .pend_i      (pend),
      .sel_id_i    (sel_id),
      .edge_sel_o  (edge_sel),
      .enable_o    (enable),
      .prio_o      (prio),
      .threshold_o (threshold),
      .claim_o     (claim),
      .complete_o  (complete),
      .swi_o       (swi)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_cfg(input string tag);
      check({tag, " edge"}, 64'(edge_sel), 64'(exp_edge));
      check({tag, " enable"}, 64'(enable), 64'(exp_en));
      check({tag, " prio"}, 64'(prio), 64'(exp_prio));
      check({tag, " threshold"}, 64'(threshold), 64'(exp_thr));
      check({tag, " swi"}, 64'(swi), 64'(exp_swi));
   endtask

   // One-cycle request; outputs are sampled at the falling edge after it
   task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(negedge clk);
      req_valid  = 1'b0;
      req_write  = 1'b0;
      snap_rdata = rsp_rdata;
      snap_claim = claim;
      snap_cmp   = complete;
   endtask

   function automatic logic [7:0] prio_addr(input int unsigned i);
      return 8'(8 + 4 * i);
   endfunction

   initial begin
      // R1: state during and after reset
      repeat (3) @(negedge clk);
      check("R1 reset rdata", 64'(rsp_rdata), 64'd0);
      check("R1 reset claim", 64'(claim), 64'd0);
      check("R1 reset complete", 64'(complete), 64'd0);
      check_cfg("R1 reset");
      rst_n = 1'b1;
      bus(1'b0, A_EDGE, 32'd0);
      check("R1 edge readback", 64'(snap_rdata), 64'd0);
      for (int i = 0; i <= N; i++) begin
         bus(1'b0, prio_addr(i), 32'd0);
         check("R1 prio readback", 64'(snap_rdata), 64'd0);
      end
      bus(1'b0, A_EN, 32'd0);
      check("R1 enable readback", 64'(snap_rdata), 64'd0);
      bus(1'b0, A_THR, 32'd0);
      check("R1 threshold readback", 64'(snap_rdata), 64'd0);
      bus(1'b0, A_SWI, 32'd0);
      check("R1 swi readback", 64'(snap_rdata), 64'd0);

      // R2: pending view, read-only
      for (int k = 0; k < 256; k += 37) begin
         pend = 8'(k);
         bus(1'b0, A_PEND, 32'd0);
         check("R2 pending read", 64'(snap_rdata), 64'(32'(k) & SRC_MASK));
      end
      pend = 8'hFF;
      bus(1'b0, A_PEND, 32'd0);
      check("R2 pending all ones", 64'(snap_rdata), 64'(SRC_MASK));
      bus(1'b1, A_PEND, 32'hFFFF_FFFF);
      check_cfg("R2 write to pending ignored");

      // R3: edge/level select
      begin
         logic [31:0] pats [4];
         pats = '{32'hFFFF_FFFF, 32'h0000_00AA, 32'h0000_0155, 32'h0};
         for (int k = 0; k < 4; k++) begin
            bus(1'b1, A_EDGE, pats[k]);
            exp_edge = 8'(pats[k] & SRC_MASK);
            check("R3 edge output", 64'(edge_sel), 64'(exp_edge));
            bus(1'b0, A_EDGE, 32'd0);
            check("R3 edge readback", 64'(snap_rdata), 64'(pats[k] & SRC_MASK));
         end
      end

      // R4: priorities, low bits only, source 0 fixed at 0
      for (int i = 0; i <= N; i++) begin
         bus(1'b1, prio_addr(i), 32'hABCD_EF00 | 32'(i * 3 + 1));
         if (i != 0) exp_prio[i*PW +: PW] = PW'(i * 3 + 1);
         check("R4 prio output", 64'(prio), 64'(exp_prio));
      end
      for (int i = 0; i <= N; i++) begin
         bus(1'b0, prio_addr(i), 32'd0);
         check("R4 prio readback", 64'(snap_rdata), (i == 0) ? 64'd0 : 64'((i * 3 + 1) % 4));
      end

      // R5: enables and threshold
      bus(1'b1, A_EN, 32'hFFFF_FFFF);
      exp_en = 8'hFE;
      check("R5 enable output", 64'(enable), 64'h0FE);
      bus(1'b1, A_EN, 32'h0000_013C);
      exp_en = 8'h3C;
      bus(1'b0, A_EN, 32'd0);
      check("R5 enable readback", 64'(snap_rdata), 64'h03C);
      bus(1'b1, A_THR, 32'hFFFF_FFFF);
      exp_thr = 2'd3;
      check("R5 threshold output", 64'(threshold), 64'd3);
      bus(1'b1, A_THR, 32'h0000_0006);
      exp_thr = 2'd2;
      bus(1'b0, A_THR, 32'd0);
      check("R5 threshold readback", 64'(snap_rdata), 64'd2);

      // R6: claim reads for every ID
      for (int id = 0; id <= N; id++) begin
         sel_id = IW'(id);
         bus(1'b0, A_CC, 32'd0);
         check("R6 claim returns id", 64'(snap_rdata), 64'(id));
         check("R6 claim pulse", 64'(snap_claim), (id == 0) ? 64'd0 : (64'd1 << id));
         check("R6 no complete on read", 64'(snap_cmp), 64'd0);
         @(negedge clk);
         check("R6 claim pulse one cycle", 64'(claim), 64'd0);
      end
      sel_id = '0;

      // R7: completion writes including ignored IDs
      begin
         logic [31:0] vals [12];
         vals = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6, 32'd7,
                  32'd8, 32'd9, 32'd100, 32'h8000_0003};
         for (int k = 0; k < 12; k++) begin
            bus(1'b1, A_CC, vals[k]);
            check("R7 complete pulse", 64'(snap_cmp),
                  (vals[k] >= 1 && vals[k] <= N) ? (64'd1 << vals[k]) : 64'd0);
            check("R7 no claim on write", 64'(snap_claim), 64'd0);
            @(negedge clk);
            check("R7 complete pulse one cycle", 64'(complete), 64'd0);
         end
         check_cfg("R7 config untouched");
      end

      // R8: software interrupt bit
      bus(1'b1, A_SWI, 32'd1);
      exp_swi = 1'b1;
      check("R8 swi set", 64'(swi), 64'd1);
      bus(1'b1, A_SWI, 32'hFFFF_FFFE);
      exp_swi = 1'b0;
      check("R8 swi clear by bit0", 64'(swi), 64'd0);
      bus(1'b1, A_SWI, 32'd3);
      exp_swi = 1'b1;
      bus(1'b0, A_SWI, 32'd0);
      check("R8 swi readback", 64'(snap_rdata), 64'd1);
      bus(1'b1, A_SWI, 32'd0);
      exp_swi = 1'b0;
      check("R8 swi cleared", 64'(swi), 64'd0);

      // R9: unmapped words
      bus(1'b0, A_EN, 32'd0);
      bus(1'b0, 8'(4 * (N + 7)), 32'd0);
      check("R9 unmapped read", 64'(snap_rdata), 64'd0);
      bus(1'b0, A_EN, 32'd0);
      bus(1'b0, 8'hFC, 32'd0);
      check("R9 unmapped top read", 64'(snap_rdata), 64'd0);
      bus(1'b1, 8'(4 * (N + 7)), 32'hFFFF_FFFF);
      bus(1'b1, 8'hFC, 32'hFFFF_FFFF);
      check_cfg("R9 unmapped write");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule